// File: doc/BRIEF.md
# Weighted-Average Output Stage for a Fuzzy Inference Engine

This block turns the fired rules of one fuzzy inference into a single crisp value. Each cycle the rule engine may present one pair: the activation degree of a rule and that rule's consequent value. The block forms the product of the two and adds it to a running weighted sum. It also keeps a running sum of the degrees. The pair flagged as last closes the inference. The crisp output is then the weighted sum divided by the degree sum. A restoring divider computes this quotient and produces one quotient bit per clock.

When every membership function is normalized and the rule connective is the product, the degrees of one inference always add up to full scale. Full scale is 2^DW, meaning 1.0 in degree units. In that case the caller raises the bypass select with the last pair. No division is then needed: the weighted sum is only shifted right by DW bits, and the result appears one clock later. The accumulators clear as the last pair is taken. The pairs of the next inference can therefore stream in while the divider is still working on the previous quotient. The caller must not present the next last pair before the previous result's done strobe.

Top module: `fmean_defuzz`

## Requirements
- R1: In divide mode with a nonzero degree sum, the result equals floor(sum(deg*cons) / sum(deg)) over the pairs of the inference.
- R2: In divide mode with a nonzero degree sum, the done strobe is high in the cycle after CW+1 rising edges, counting the edge that takes the last pair as the first. The divider stays busy for exactly CW cycles.
- R3: The weighted sum holds DW+CW+IW bits and the degree sum holds DW+IW bits. 2^IW pairs at maximum degree and maximum consequent therefore give an exact result (255 with the default widths).
- R4: With bypass high on the last pair, the result is bits [DW+CW-1:DW] of the weighted sum. Done rises one edge after the last pair is taken.
- R5: In divide mode with a degree sum of zero, the result is 0 and done still rises one edge after the last pair.
- R6: Done is high for one cycle per inference. The result keeps its value in every cycle in which done is low.
- R7: Taking the last pair empties both sums. Pairs of the next inference are accumulated while the previous division runs, and the two results do not disturb each other.
- R8: A cycle with in_valid low leaves both sums unchanged, whatever in_deg and in_cons carry.
- R9: After reset the result is 0, done is low and both sums are empty.
- R10: Only the bypass value presented with the last pair selects the mode. Bypass on earlier pairs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A pair is presented this cycle |
| in_last | input | 1 | This pair closes the inference |
| in_bypass | input | 1 | Sampled with the last pair: skip division, shift by DW |
| in_deg | input | DW | Rule activation degree |
| in_cons | input | CW | Rule consequent value |
| out_done | output | 1 | One-cycle strobe: new result valid |
| out_y | output | CW | Crisp output, held until the next strobe |

## Verification
The bench builds the block with its defaults: DW=8, CW=8 and IW=2. This gives an eight-cycle divider and a four-pair limit. With these widths, four pairs at degree 255 and consequent 255 drive both sums to within a few percent of their limits, so an accumulator that is one bit too narrow gives a wrong quotient. The eight-cycle divide window is short enough to overlap a three-pair accumulation of the next inference. The 256 full-scale value lets bypass cases use degree pairs such as 128+128.

// File: rtl/fmean_defuzz.sv
module fmean_defuzz #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          in_bypass,
  input  logic [DW-1:0] in_deg,
  input  logic [CW-1:0] in_cons,
  output logic          out_done,
  output logic [CW-1:0] out_y
);
  localparam int WW = DW + CW + IW;
  localparam int AW = DW + IW;
  localparam int NW = $clog2(CW + 1);

  logic [WW-1:0] wacc, wtot;
  logic [AW-1:0] aacc, atot;
  logic [DW+CW-1:0] prod;
  logic take;

  assign prod = in_deg * in_cons;
  assign wtot = wacc + WW'(prod);
  assign atot = aacc + AW'(in_deg);
  assign take = in_valid & in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wacc <= '0;
      aacc <= '0;
    end else if (in_valid) begin
      wacc <= in_last ? '0 : wtot;
      aacc <= in_last ? '0 : atot;
    end
  end

  logic [AW-1:0] rem, dvs;
  logic [CW-1:0] dlo;
  logic [NW-1:0] cnt;
  logic busy;
  logic [AW:0] trial, diff;
  logic ge;

  assign trial = {rem, dlo[CW-1]};
  assign diff  = trial - {1'b0, dvs};
  assign ge    = trial >= {1'b0, dvs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem      <= '0;
      dvs      <= '0;
      dlo      <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
      out_done <= 1'b0;
      out_y    <= '0;
    end else begin
      out_done <= 1'b0;
      if (take) begin
        if (in_bypass) begin
          out_y    <= wtot[DW +: CW];
          out_done <= 1'b1;
        end else if (atot == '0) begin
          out_y    <= '0;
          out_done <= 1'b1;
        end else begin
          rem  <= wtot[WW-1:CW];
          dlo  <= wtot[CW-1:0];
          dvs  <= atot;
          cnt  <= NW'(CW);
          busy <= 1'b1;
        end
      end else if (busy) begin
        rem <= ge ? diff[AW-1:0] : trial[AW-1:0];
        dlo <= {dlo[CW-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == NW'(1)) begin
          busy     <= 1'b0;
          out_done <= 1'b1;
          out_y    <= {dlo[CW-2:0], ge};
        end
      end
    end
  end
endmodule

module fmean_defuzz_chk #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int IW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_last,
  input logic             in_bypass,
  input logic             out_done,
  input logic [CW-1:0]    out_y,
  input logic             busy,
  input logic [DW+IW-1:0] atot,
  input logic [DW+IW-1:0] aacc
);
  logic [31:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= busy ? run + 1 : '0;
  end

  AST_BYPASS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_last && in_bypass |=> out_done); // R4
  AST_ZERO_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_last && !in_bypass && atot == '0 |=> out_done && out_y == '0); // R5
  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> out_y == $past(out_y)); // R6
  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < CW); // R2
  AST_DIV_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_done); // R2
  AST_ACC_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_last |=> aacc >= $past(aacc)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> aacc == $past(aacc)); // R8
endmodule

bind fmean_defuzz fmean_defuzz_chk #(.DW(DW), .CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .in_bypass(in_bypass), .out_done(out_done), .out_y(out_y),
  .busy(busy), .atot(atot), .aacc(aacc)
);

// File: tb/sim_fmean_defuzz.sv
`timescale 1ns/1ps
module sim_fmean_defuzz;
  localparam int DW = 8, CW = 8, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_bypass = 1'b0;
  logic [DW-1:0] in_deg = '0;
  logic [CW-1:0] in_cons = '0;
  logic out_done;
  logic [CW-1:0] out_y;

  int checks = 0, errors = 0;
  int pa [0:7];
  int pc [0:7];
  bit pb [0:7];

  always #5 clk = ~clk;

  fmean_defuzz #(.DW(DW), .CW(CW), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_bypass(in_bypass), .in_deg(in_deg), .in_cons(in_cons),
    .out_done(out_done), .out_y(out_y)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expect_y(input int n, input bit byp);
    int ws = 0, as = 0;
    for (int i = 0; i < n; i++) begin
      ws += pa[i] * pc[i];
      as += pa[i];
    end
    if (byp) return (ws >> DW) & ((1 << CW) - 1);
    if (as == 0) return 0;
    return ws / as;
  endfunction

  task automatic send(input int a, input int c, input bit last, input bit byp, input bit gap);
    @(negedge clk);
    in_valid = 1'b1; in_deg = DW'(a); in_cons = CW'(c);
    in_last = last; in_bypass = byp;
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0; in_deg = '1; in_cons = '1; in_last = 1'b1; in_bypass = 1'b1;
    end
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!out_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic infer(input int n, input bit gap, input int exp_lat, input string tag);
    int lat, ey;
    bit byp = pb[n-1];
    for (int i = 0; i < n; i++) send(pa[i], pc[i], i == n - 1, pb[i], gap && i != n - 1);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_bypass = 1'b0;
    wait_done(lat);
    ey = expect_y(n, byp);
    chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
    chk(out_y == CW'(ey), {tag, " result"}, int'(out_y), ey);
    @(negedge clk);
    chk(!out_done, {tag, " R6 done one cycle"}, int'(out_done), 0);
    chk(out_y == CW'(ey), {tag, " R6 result held"}, int'(out_y), ey);
  endtask

  task automatic t_divide_basic();
    pa[0] = 200; pc[0] = 40; pb[0] = 0;
    pa[1] = 55;  pc[1] = 250; pb[1] = 0;
    infer(2, 0, CW + 1, "R1 R2 two pairs");
    pa[0] = 1; pc[0] = 255; pb[0] = 0;
    infer(1, 0, CW + 1, "R1 single pair");
    pa[0] = 10; pc[0] = 3; pa[1] = 20; pc[1] = 7; pa[2] = 30; pc[2] = 11;
    pb[0] = 0; pb[1] = 0; pb[2] = 0;
    infer(3, 0, CW + 1, "R1 three pairs");
  endtask

  task automatic t_full_scale();
    for (int i = 0; i < 4; i++) begin pa[i] = 255; pc[i] = 255; pb[i] = 0; end
    infer(4, 0, CW + 1, "R3 max pairs");
  endtask

  task automatic t_bypass();
    pa[0] = 128; pc[0] = 100; pb[0] = 1;
    pa[1] = 128; pc[1] = 200; pb[1] = 1;
    infer(2, 0, 1, "R4 bypass");
    pa[0] = 64; pc[0] = 17; pa[1] = 192; pc[1] = 240; pb[0] = 0; pb[1] = 1;
    infer(2, 0, 1, "R4 bypass last only");
  endtask

  task automatic t_bypass_early_only();
    pa[0] = 100; pc[0] = 90; pb[0] = 1;
    pa[1] = 50;  pc[1] = 30; pb[1] = 0;
    infer(2, 0, CW + 1, "R10 bypass on early pair");
  endtask

  task automatic t_zero();
    pa[0] = 0; pc[0] = 200; pb[0] = 0;
    pa[1] = 0; pc[1] = 99;  pb[1] = 0;
    infer(2, 0, 1, "R5 zero sum");
  endtask

  task automatic t_gaps();
    pa[0] = 90; pc[0] = 10; pa[1] = 70; pc[1] = 220; pa[2] = 5; pc[2] = 130;
    pb[0] = 0; pb[1] = 0; pb[2] = 0;
    infer(3, 1, CW + 1, "R8 idle cycles");
  endtask

  task automatic t_overlap();
    int lat;
    send(40, 60, 1, 0, 0);
    send(30, 250, 0, 1, 0);
    send(60, 5, 0, 0, 0);
    send(90, 180, 0, 0, 0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_bypass = 1'b0;
    wait_done(lat);
    chk(lat == CW + 1 - 3, "R7 first result latency", lat, CW + 1 - 3);
    chk(out_y == 8'd60, "R7 first result", int'(out_y), 60);
    pa[0] = 30; pc[0] = 250; pa[1] = 60; pc[1] = 5; pa[2] = 90; pc[2] = 180; pa[3] = 20; pc[3] = 77;
    send(20, 77, 1, 0, 0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    wait_done(lat);
    chk(lat == CW + 1, "R7 second latency", lat, CW + 1);
    chk(out_y == CW'(expect_y(4, 0)), "R7 second result", int'(out_y), expect_y(4, 0));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_y == '0, "R9 reset result", int'(out_y), 0);
    chk(!out_done, "R9 reset done", int'(out_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    pa[0] = 77; pc[0] = 123; pb[0] = 0;
    infer(1, 0, CW + 1, "R9 empty sums after reset");
    t_divide_basic();
    t_full_scale();
    t_bypass();
    t_bypass_early_only();
    t_zero();
    t_gaps();
    t_overlap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule